// File: doc/BRIEF.md
# Byte-Parallel Transfer CRC-8

This block keeps the running checksum of a serial register transfer. The serial slave that owns framing hands it one completed byte at a time, command bytes included. Each accepted byte is folded into an 8-bit remainder in a single clock, using an unrolled division network instead of a one-bit-per-clock shifter. The generator is x^8 + x^4 + x^3 + x^2 + 1. Each byte enters most significant bit first.

A clear request starts a new calculation. The slave raises it at the start of every transfer and whenever chip select aborts one. The clear loads the all-ones preset. When the slave is ready to send the trailer word, it raises the finalize request. One clock later the block presents the bit-inverted remainder together with a one-cycle valid pulse, and it holds that value until the next finalize.

Top module: `crc8_xfer_chk`

## Requirements
- R1: After a synchronous active-low reset, `crc_vld_o` is 0 and `crc_o` is 0x00. The remainder holds the 0xFF preset, so bytes fed without a clear are checked as a fresh calculation.
- R2: Each byte with `byte_vld_i`=1 updates the remainder as if its bits were shifted in one at a time, bit 7 first. Each bit shift uses the polynomial 0x1D, that is x^8+x^4+x^3+x^2+1 with the x^8 term implied.
- R3: `clr_i`=1 with `byte_vld_i`=0 loads the remainder with 0xFF. A following finalize with no byte in between then yields 0x00.
- R4: `crc_o` carries the bitwise inverse of the remainder.
- R5: When `clr_i` and `byte_vld_i` are both 1 in the same cycle, the preset is applied first and then the byte. The result is the CRC of that byte alone.
- R6: In a cycle with `clr_i`=0 and `byte_vld_i`=0, the remainder does not change. Bytes across a transfer therefore accumulate, in order, regardless of idle gaps.
- R7: `fin_i`=1 in cycle n makes `crc_o` show the inverted remainder in cycle n+1, and `crc_vld_o` is 1 for exactly that cycle. The remainder includes any byte strobed in cycle n. In cycles not preceded by a finalize, `crc_vld_o` is 0 and `crc_o` holds its value.
- R8: The ASCII string "123456789" fed after a clear gives `crc_o` = 0x4B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_i | input | 1 | Start or abort of a transfer; presets the remainder |
| byte_vld_i | input | 1 | A completed byte is present on byte_i |
| byte_i | input | 8 | Byte to fold into the checksum, bit 7 sent first |
| fin_i | input | 1 | Request the inverted checksum for the trailer |
| crc_o | output | 8 | Inverted remainder, held between finalize requests |
| crc_vld_o | output | 1 | One-cycle pulse: crc_o was just updated |

## Verification
A corrupted remainder never shows directly. It shows only at the next finalize, one cycle after `fin_i`, as a wrong `crc_o`. Comparing every finalized checksum against a bit-serial model therefore exposes any bad network tap, preset or inversion within a single transfer.

A remainder that drifts during idle cycles, or one that ignores a clear, shows as a mismatch on the following trailer. The same holds when a byte and a clear collide in one cycle. Directed cases target the empty transfer, the clear-plus-byte collision, a finalize that coincides with a byte, and the standard nine-byte check string.

// File: rtl/crc8_pkg.sv
// Package: shared constants for the transfer checksum.
// Assumes an 8-bit remainder and byte-wide input; all modules take these as
// parameter defaults so a different width can be chosen per instance.
package crc8_pkg;
    localparam int          CRC8_W    = 8;
    localparam int          CRC8_DW   = 8;
    localparam logic [7:0]  CRC8_POLY = 8'h1D;
    localparam logic [7:0]  CRC8_INIT = 8'hFF;
endpackage

// File: rtl/crc8_byte_net.sv
// Module: crc8_byte_net
// Purely combinational division network folding DW data bits into a W-bit
// remainder in one step. Equivalent to DW bit-serial shifts, MSB of dat_i
// first. Assumes POLY omits the implied x^W term.
module crc8_byte_net #(
    parameter int             W    = crc8_pkg::CRC8_W,
    parameter int             DW   = crc8_pkg::CRC8_DW,
    parameter logic [W-1:0]   POLY = crc8_pkg::CRC8_POLY
) (
    input  logic [W-1:0]  rem_i,
    input  logic [DW-1:0] dat_i,
    output logic [W-1:0]  rem_o
);
    logic [W-1:0] stage [0:DW];
    logic [DW-1:0] fb;

    assign stage[0] = rem_i;

    // One unrolled shift stage per data bit, highest bit entering first.
    for (genvar g = 0; g < DW; g++) begin : g_stage
        assign fb[g]         = stage[g][W-1] ^ dat_i[DW-1-g];
        assign stage[g+1]    = {stage[g][W-2:0], 1'b0} ^ ({W{fb[g]}} & POLY);
    end

    assign rem_o = stage[DW];

    // Network is linear: zero remainder with zero data must stay zero.
    always_comb begin
        // R2
        if (rem_i == '0 && dat_i == '0)
            zero_in_zero_out_chk: assert (rem_o == '0);
    end
endmodule

// File: rtl/crc8_rem_reg.sv
// Module: crc8_rem_reg
// Holds the running remainder. A clear selects the preset as the base; a byte
// strobe then folds the byte into that base, so clear plus byte in one cycle
// gives the checksum of that byte alone. rem_nxt exposes the value to be
// stored this cycle so a finalize can include a same-cycle byte.
module crc8_rem_reg #(
    parameter int             W    = crc8_pkg::CRC8_W,
    parameter int             DW   = crc8_pkg::CRC8_DW,
    parameter logic [W-1:0]   POLY = crc8_pkg::CRC8_POLY,
    parameter logic [W-1:0]   INIT = crc8_pkg::CRC8_INIT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          vld_i,
    input  logic [DW-1:0] dat_i,
    output logic [W-1:0]  rem_q,
    output logic [W-1:0]  rem_nxt
);
    logic [W-1:0] base;
    logic [W-1:0] upd;

    // Pick the starting point: preset on clear, otherwise the stored value.
    always_comb base = clr_i ? INIT : rem_q;

    crc8_byte_net #(.W(W), .DW(DW), .POLY(POLY)) u_net (
        .rem_i (base),
        .dat_i (dat_i),
        .rem_o (upd)
    );

    // Choose the value stored this cycle: updated on a byte, else the base.
    always_comb rem_nxt = vld_i ? upd : base;

    // Remainder register with synchronous preset on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) rem_q <= INIT;
        else        rem_q <= rem_nxt;
    end

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !vld_i) |=> $stable(rem_q));

    // R3
    clear_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !vld_i) |=> (rem_q == INIT));
endmodule

// File: rtl/crc8_xfer_chk.sv
// Module: crc8_xfer_chk (top)
// Transfer checksum engine. The serial slave feeds completed bytes, clears at
// transfer start or abort, and requests the inverted remainder for the
// trailer word. Assumes the slave decides which bytes count and when to clear.
module crc8_xfer_chk #(
    parameter int             W    = crc8_pkg::CRC8_W,
    parameter int             DW   = crc8_pkg::CRC8_DW,
    parameter logic [W-1:0]   POLY = crc8_pkg::CRC8_POLY,
    parameter logic [W-1:0]   INIT = crc8_pkg::CRC8_INIT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          byte_vld_i,
    input  logic [DW-1:0] byte_i,
    input  logic          fin_i,
    output logic [W-1:0]  crc_o,
    output logic          crc_vld_o
);
    logic [W-1:0] rem_q;
    logic [W-1:0] rem_nxt;

    crc8_rem_reg #(.W(W), .DW(DW), .POLY(POLY), .INIT(INIT)) u_rem (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr_i),
        .vld_i   (byte_vld_i),
        .dat_i   (byte_i),
        .rem_q   (rem_q),
        .rem_nxt (rem_nxt)
    );

    // Capture the inverted remainder on finalize and pulse the valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_o     <= '0;
            crc_vld_o <= 1'b0;
        end else begin
            crc_vld_o <= fin_i;
            if (fin_i) crc_o <= ~rem_nxt;
        end
    end

    // R7
    fin_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin_i |=> crc_vld_o);

    // R7
    no_fin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fin_i |=> (!crc_vld_o && $stable(crc_o)));

    // R4
    out_inverted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_i && !clr_i && !byte_vld_i) |=> (crc_o == ~$past(rem_q)));
endmodule

// File: tb/crc8_xfer_chk_tb.sv
module crc8_xfer_chk_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr_i = 1'b0;
    logic       byte_vld_i = 1'b0;
    logic [7:0] byte_i = 8'h00;
    logic       fin_i = 1'b0;
    logic [7:0] crc_o;
    logic       crc_vld_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    crc8_xfer_chk u_dut (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .byte_vld_i(byte_vld_i),
        .byte_i(byte_i), .fin_i(fin_i), .crc_o(crc_o), .crc_vld_o(crc_vld_o)
    );

    // Bit-serial reference: MSB first, polynomial 0x1D.
    function automatic logic [7:0] ref_byte(logic [7:0] r, logic [7:0] b);
        logic [7:0] x = r;
        for (int i = 7; i >= 0; i--) begin
            logic f = x[7] ^ b[i];
            x = {x[6:0], 1'b0} ^ (f ? 8'h1D : 8'h00);
        end
        return x;
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs at a falling edge; return after the next one.
    task automatic step(logic c, logic v, logic [7:0] b, logic f);
        clr_i = c; byte_vld_i = v; byte_i = b; fin_i = f;
        @(negedge clk);
    endtask

    logic [7:0] model;
    logic [7:0] held;
    string      s9 = "123456789";

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        step(0, 0, 8'h00, 0);
        step(0, 0, 8'h00, 0);
        // R1 reset state
        check("R1 crc_o", crc_o, 8'h00);
        check("R1 vld", {7'd0, crc_vld_o}, 8'h00);
        rst_n = 1'b1;
        // R1 preset after reset: one byte then finalize without clear
        step(0, 1, 8'hA5, 0);
        step(0, 0, 8'h00, 1);
        check("R1 preset", crc_o, ~ref_byte(8'hFF, 8'hA5));
        check("R7 vld pulse", {7'd0, crc_vld_o}, 8'h01);
        step(0, 0, 8'h00, 0);
        check("R7 vld drop", {7'd0, crc_vld_o}, 8'h00);
        // R3 empty transfer
        step(1, 0, 8'h00, 0);
        step(0, 0, 8'h00, 1);
        check("R3 empty", crc_o, 8'h00);
        // R8 standard check string
        step(1, 0, 8'h00, 0);
        for (int i = 0; i < 9; i++) step(0, 1, s9[i], 0);
        step(0, 0, 8'h00, 1);
        check("R8 check", crc_o, 8'h4B);
        // R5 clear plus byte collision after garbage
        step(1, 1, 8'h33, 0);
        step(0, 1, 8'h77, 0);
        step(1, 1, 8'h5C, 0);
        step(0, 0, 8'h00, 1);
        check("R5 collide", crc_o, ~ref_byte(8'hFF, 8'h5C));
        // R7 finalize coinciding with a byte, then held value
        step(1, 1, 8'h10, 0);
        step(0, 1, 8'hEE, 1);
        model = ref_byte(ref_byte(8'hFF, 8'h10), 8'hEE);
        check("R7 same-cycle byte", crc_o, ~model);
        held = crc_o;
        step(0, 1, 8'h42, 0);
        step(0, 0, 8'h00, 0);
        check("R7 held", crc_o, held);
        check("R7 no pulse", {7'd0, crc_vld_o}, 8'h00);
        // R4 inversion: continue the running transfer
        model = ref_byte(model, 8'h42);
        step(0, 0, 8'h00, 1);
        check("R4 inverted", crc_o, ~model);
        // R2 R6 random transfers with idle gaps
        for (int t = 0; t < 40; t++) begin
            int len = 1 + ($urandom % 12);
            model = 8'hFF;
            step(1, 0, 8'h00, 0);
            for (int k = 0; k < len; k++) begin
                logic [7:0] b = 8'($urandom);
                if ($urandom % 3 == 0) step(0, 0, 8'h00, 0);
                step(0, 1, b, 0);
                model = ref_byte(model, b);
            end
            step(0, 0, 8'h00, 1);
            check("R2 R6 random", crc_o, ~model);
        end
        // R6 idle gap must not alter the running remainder
        step(1, 1, 8'hC3, 0);
        repeat (5) step(0, 0, 8'h00, 0);
        step(0, 0, 8'h00, 1);
        check("R6 idle", crc_o, ~ref_byte(8'hFF, 8'hC3));
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule